// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block places the analog closed-caption waveform onto a digital luma stream. It watches the line number and a start-of-line strobe. On the first-field caption line or the second-field caption line, if that line is enabled, it replaces the incoming luma with a two-level pattern. The pattern is 7 run-in cycles, then the start bits 0, 0, 1, then the two caption bytes stored for that line. On every other line, the luma passes through unchanged.

The bit clock runs at 32 times the line rate. It is derived from the pixel clock enable with a fractional accumulator that adds 16 and wraps at 429, which gives 26.8125 pixel clocks per bit with no long-term drift. A small host write port sets the two per-line enable bits and the four caption bytes. Each line has its own interrupt bit, which rises once that line's last data bit has been sent. The host clears it by writing 1 to it.

Top module: `cc_line_inserter`

## Requirements
- R1: The output equals `luma_in` whenever the last accepted start-of-line strobe arrived on a line other than `LINE_F1` (21) or `LINE_F2` (284), or arrived on one of them while that line's enable bit was 0. Enable bit 0 belongs to `LINE_F1` and enable bit 1 belongs to `LINE_F2`.
- R2: Host writes take effect at the clock edge. The address map is:
  - address 0: enable bits [1:0]
  - address 1: first byte of `LINE_F1`
  - address 2: second byte of `LINE_F1`
  - address 3: first byte of `LINE_F2`
  - address 4: second byte of `LINE_F2`

  The bytes a line sends are the register values at the moment of its start-of-line strobe. A write made later on that line does not change the waveform.
- R3: On an active caption line, the output holds `LVL_BLANK` for the first `START_DELAY` pixel clocks after the strobe. It also holds `LVL_BLANK` from the end of the 33rd bit period until the next strobe.
- R4: Bit periods 0 to 13 form the run-in. Even-numbered periods are low and odd-numbered periods are high, so the run-in is 7 full low/high cycles.
- R5: Bit periods 14, 15 and 16 carry 0, 0 and 1.
- R6: Bit periods 17 to 24 carry the line's first byte, and periods 25 to 32 carry its second byte. Each byte is sent least significant bit first.
- R7: Count n pixel clocks from the point where the start delay ends. At that count, the bit period index is floor(n·16/429).
- R8: A 0 bit drives `LVL_BLANK`, the 0 IRE code. A 1 bit drives `LVL_HIGH`, the 50 IRE code.
- R9: `irq[i]` rises on the pixel clock that ends bit period 32 of caption line i, with i = 0 for `LINE_F1` and i = 1 for `LINE_F2`. It is 0 after reset.
- R10: Writing address 5 clears each `irq` bit whose `wr_data` bit is 1. When a set and a clear fall on the same edge, the set wins. The other `irq` bit is not affected.
- R11: While `pix_ce` is 0, the timing state does not advance and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | input | 1 | Pixel clock enable |
| sol | input | 1 | Start-of-active-line strobe, taken only when `pix_ce` is high |
| line_num | input | LINE_W | Current line number |
| luma_in | input | LUMA_W | Normal luma |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| luma_out | output | LUMA_W | Luma after caption insertion |
| irq | output | 2 | Per-line bytes-consumed interrupts |

## Verification
The hardest cases to reach are the exact edges of the fractional bit periods. They must be checked while `pix_ce` arrives irregularly, including long pauses in the middle of a waveform, and together with host writes that land during a line.

The bench drives `pix_ce` high on a random two thirds of the cycles. It inserts 40-cycle pauses at chosen points inside the waveform and writes caption registers partway through a line. Every pixel sample is compared with a model that computes the bit index from the pixel count with integer arithmetic. Directed byte pairs such as 0x01/0x80 and 0x00/0xFF expose bit-order and byte-order errors.

// File: rtl/cc_line_inserter.sv
module cc_line_inserter #(
  parameter int LUMA_W      = 10,
  parameter int LINE_W      = 10,
  parameter int LINE_F1     = 21,
  parameter int LINE_F2     = 284,
  parameter int START_DELAY = 64,
  parameter int BIT_NUM     = 16,
  parameter int BIT_DEN     = 429,
  parameter int LVL_BLANK   = 240,
  parameter int LVL_HIGH    = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_ce,
  input  logic              sol,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LUMA_W-1:0] luma_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [LUMA_W-1:0] luma_out,
  output logic [1:0]        irq
);
  localparam int NBITS = 33;
  localparam int ACC_W = $clog2(BIT_DEN + BIT_NUM);
  localparam int PC_W  = $clog2(START_DELAY + 2);

  logic [1:0]       en;
  logic [7:0]       cc_byte [4];
  logic             active, slot;
  logic [15:0]      snap;
  logic [PC_W-1:0]  pcnt;
  logic [ACC_W-1:0] acc;
  logic [5:0]       bidx;
  logic [1:0]       irq_nx;

  wire hit0 = (line_num == LINE_W'(LINE_F1)) && en[0];
  wire hit1 = (line_num == LINE_W'(LINE_F2)) && en[1];
  wire strobe  = pix_ce && sol;
  wire started = (pcnt == PC_W'(START_DELAY));
  wire sending = active && started && (bidx < 6'(NBITS));
  wire [ACC_W-1:0] acc_sum = acc + ACC_W'(BIT_NUM);
  wire bit_end = acc_sum >= ACC_W'(BIT_DEN);
  wire [3:0] data_idx = 4'(bidx - 6'd17);
  wire cur_bit = (bidx < 6'd14) ? bidx[0] :
                 (bidx < 6'd17) ? (bidx == 6'd16) : snap[data_idx];
  wire last_end = pix_ce && !sol && sending && bit_end && (bidx == 6'(NBITS - 1));

  assign luma_out = !active ? luma_in :
                    (sending && cur_bit) ? LUMA_W'(LVL_HIGH) : LUMA_W'(LVL_BLANK);

  always_comb begin
    irq_nx = irq;
    if (wr_en && wr_addr == 3'd5) irq_nx = irq_nx & ~wr_data[1:0];
    if (last_end) irq_nx[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= '0;
      cc_byte <= '{default: '0};
      irq     <= '0;
      active  <= 1'b0;
      slot    <= 1'b0;
      snap    <= '0;
      pcnt    <= '0;
      acc     <= '0;
      bidx    <= '0;
    end else begin
      irq <= irq_nx;
      if (wr_en) begin
        case (wr_addr)
          3'd0: en <= wr_data[1:0];
          3'd1: cc_byte[0] <= wr_data;
          3'd2: cc_byte[1] <= wr_data;
          3'd3: cc_byte[2] <= wr_data;
          3'd4: cc_byte[3] <= wr_data;
          default: ;
        endcase
      end
      if (strobe) begin
        active <= hit0 || hit1;
        slot   <= hit1 && !hit0;
        snap   <= (hit1 && !hit0) ? {cc_byte[3], cc_byte[2]} : {cc_byte[1], cc_byte[0]};
        pcnt   <= '0;
        acc    <= '0;
        bidx   <= '0;
      end else if (pix_ce && active) begin
        if (!started) pcnt <= pcnt + 1'b1;
        else if (bidx < 6'(NBITS)) begin
          acc <= bit_end ? acc_sum - ACC_W'(BIT_DEN) : acc_sum;
          if (bit_end) bidx <= bidx + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/cc_line_inserter_chk.sv
module cc_line_inserter_chk #(
  parameter int LUMA_W    = 10,
  parameter int ACC_W     = 9,
  parameter int BIT_DEN   = 429,
  parameter int LVL_BLANK = 240,
  parameter int LVL_HIGH  = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_ce,
  input logic              sol,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic [LUMA_W-1:0] luma_out,
  input logic [1:0]        irq,
  input logic              active,
  input logic              slot,
  input logic              started,
  input logic [5:0]        bidx,
  input logic [ACC_W-1:0]  acc
);
  // R7: the phase never reaches one full bit period
  assert_acc_range_R7: assert property (@(posedge clk) disable iff (rst)
    acc < ACC_W'(BIT_DEN));

  // R7: the bit index steps by at most one per clock between strobes
  assert_bit_step_R7: assert property (@(posedge clk) disable iff (rst)
    !(pix_ce && sol) |=> (bidx == $past(bidx) || bidx == $past(bidx) + 6'd1));

  // R3: the bit index saturates after the last period
  assert_bit_limit_R3: assert property (@(posedge clk) disable iff (rst)
    bidx <= 6'd33);

  // R8: an active waveform uses only the two caption levels
  assert_two_levels_R8: assert property (@(posedge clk) disable iff (rst)
    (active && started) |-> (luma_out == LUMA_W'(LVL_BLANK) || luma_out == LUMA_W'(LVL_HIGH)));

  // R11: without a pixel enable the timing state holds
  assert_ce_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    !pix_ce |=> ($stable(bidx) && $stable(acc) && $stable(active)));

  // R10: an interrupt only falls through a clearing write
  assert_irq0_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq[0]) |-> $past(wr_en && wr_addr == 3'd5 && wr_data[0]));
  assert_irq1_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq[1]) |-> $past(wr_en && wr_addr == 3'd5 && wr_data[1]));

  // R9: an interrupt rises only at the end of the last bit of its own line
  assert_irq0_set_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq[0]) |-> ($past(bidx) == 6'd32 && !$past(slot) && bidx == 6'd33));
  assert_irq1_set_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq[1]) |-> ($past(bidx) == 6'd32 && $past(slot) && bidx == 6'd33));
endmodule

bind cc_line_inserter cc_line_inserter_chk #(
  .LUMA_W(LUMA_W), .ACC_W(ACC_W), .BIT_DEN(BIT_DEN),
  .LVL_BLANK(LVL_BLANK), .LVL_HIGH(LVL_HIGH)
) u_chk (
  .clk(clk), .rst(rst), .pix_ce(pix_ce), .sol(sol), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .luma_out(luma_out), .irq(irq),
  .active(active), .slot(slot), .started(started), .bidx(bidx), .acc(acc)
);

// File: tb/cc_line_inserter_tb.sv
`timescale 1ns/1ps
module cc_line_inserter_tb;
  localparam int D = 64, NUM = 16, DEN = 429, BLANK = 240, HIGH = 512;

  logic clk = 1'b0;
  logic rst, pix_ce, sol, wr_en;
  logic [9:0] line_num, luma_in, luma_out;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] irq;

  always #2.5 clk = ~clk;

  cc_line_inserter u_dut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .sol(sol), .line_num(line_num),
    .luma_in(luma_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .luma_out(luma_out), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0]  m_en, m_irq;
  logic [7:0]  m_byte [4];
  logic        m_act, m_slot;
  logic [15:0] m_snap;
  int          m_p;

  function automatic int kof(int p);
    int k;
    if (p < D) return -1;
    k = ((p - D) * NUM) / DEN;
    return (k > 33) ? 33 : k;
  endfunction

  function automatic logic [9:0] exp_luma(logic [9:0] lin);
    int k;
    logic b;
    if (!m_act) return lin;
    k = kof(m_p);
    if (k < 0 || k >= 33) return 10'(BLANK);
    if (k < 14) b = k[0];
    else if (k < 17) b = (k == 16);
    else b = m_snap[k-17];
    return b ? 10'(HIGH) : 10'(BLANK);
  endfunction

  function automatic string tag_of(bit ce);
    int k;
    string s;
    k = kof(m_p);
    if (!m_act) s = "R1";
    else if (k < 0 || k >= 33) s = "R3 R7";
    else if (k < 14) s = "R4 R7 R8";
    else if (k < 17) s = "R5 R7 R8";
    else s = "R6 R2 R7 R8";
    if (!ce) s = {s, " R11"};
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(bit ce, bit s, logic [9:0] ln, bit w, logic [2:0] a, logic [7:0] d);
    int k0;
    logic [1:0] clr;
    pix_ce = ce; sol = s; line_num = ln; wr_en = w; wr_addr = a; wr_data = d;
    luma_in = 10'($urandom);
    @(posedge clk);
    clr = (w && a == 3'd5) ? d[1:0] : 2'b00;
    if (ce && s) begin
      m_p = 0;
      if (ln == 10'd21 && m_en[0]) begin m_act = 1; m_slot = 0; m_snap = {m_byte[1], m_byte[0]}; end
      else if (ln == 10'd284 && m_en[1]) begin m_act = 1; m_slot = 1; m_snap = {m_byte[3], m_byte[2]}; end
      else m_act = 0;
      m_irq = m_irq & ~clr;
    end else begin
      m_irq = m_irq & ~clr;
      if (ce && m_act) begin
        k0 = kof(m_p);
        m_p++;
        if (k0 == 32 && kof(m_p) == 33) m_irq[m_slot] = 1'b1;
      end
    end
    if (w) begin
      if (a == 3'd0) m_en = d[1:0];
      else if (a >= 3'd1 && a <= 3'd4) m_byte[a-1] = d;
    end
    @(negedge clk);
    check(tag_of(ce), 32'(luma_out), 32'(exp_luma(luma_in)));
    check("R9 R10 irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic hw(logic [2:0] a, logic [7:0] d);
    tick(1'b0, 1'b0, 10'd0, 1'b1, a, d);
  endtask

  task automatic run_line(logic [9:0] ln, int nce, int gap_at, int wr_at, logic [2:0] wa);
    int c = 0;
    tick(1'b1, 1'b1, ln, 1'b0, 3'd0, 8'd0);
    while (c < nce) begin
      bit ce = ($urandom % 3) != 0;
      if (c == gap_at) begin
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, ln, 1'b0, 3'd0, 8'd0);
        gap_at = -1;
      end
      if (c == wr_at) begin
        tick(ce, 1'b0, ln, 1'b1, wa, 8'($urandom));
        wr_at = -1;
      end else tick(ce, 1'b0, ln, 1'b0, 3'd0, 8'd0);
      if (ce) c++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; pix_ce = 0; sol = 0; line_num = 0; luma_in = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    m_en = 0; m_irq = 0; m_act = 0; m_slot = 0; m_snap = 0; m_p = 0;
    for (int i = 0; i < 4; i++) m_byte[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    luma_in = 10'd123;
    #0.1;
    check("R1 reset passthrough", 32'(luma_out), 32'd123);
    check("R9 reset irq", 32'(irq), 32'd0);

    hw(3'd0, 8'h03);
    hw(3'd1, 8'h01); hw(3'd2, 8'h80); hw(3'd3, 8'h00); hw(3'd4, 8'hFF);
    run_line(10'd21, 1000, 300, -1, 3'd0);
    check("R9 irq line 1 set", 32'(irq[0]), 32'd1);
    hw(3'd5, 8'h01);
    check("R10 irq cleared", 32'(irq), 32'd0);
    run_line(10'd284, 1000, 700, 200, 3'd3);
    check("R9 irq line 2 set", 32'(irq[1]), 32'd1);
    hw(3'd5, 8'h02);
    hw(3'd0, 8'h02);
    run_line(10'd21, 1000, -1, -1, 3'd0);
    check("R1 disabled line leaves irq", 32'(irq[0]), 32'd0);
    run_line(10'd100, 300, -1, -1, 3'd0);

    for (int n = 0; n < 8; n++) begin
      logic [9:0] ln;
      int sel = $urandom % 4;
      ln = (sel == 0) ? 10'd21 : (sel == 1) ? 10'd284 : (sel == 2) ? 10'd21 : 10'(1 + $urandom % 500);
      hw(3'd0, 8'($urandom));
      for (int r = 1; r <= 4; r++) hw(3'(r), 8'($urandom));
      if ($urandom % 2) hw(3'd5, 8'($urandom));
      run_line(ln, 950 + $urandom % 100, 50 + $urandom % 900, $urandom % 900, 3'(1 + $urandom % 4));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule